// File: doc/BRIEF.md
# DMA Protected Memory Range Checker

This block guards one window of physical memory below 4 GB against DMA access. Software programs a base register and a limit register, each holding a 1 MB block number in address bits 31:20, and then sets an enable bit. One cycle later a protection-active status bit goes high. From then on, every DMA address presented with a valid strobe is compared against the window. A one-cycle-late `hit` output tells the surrounding fabric to block the request.

The window is inclusive on both ends. The base names the first byte of its 1 MB block. The limit is widened to the last byte of its block, because its low twenty bits are taken as ones. Programming base and limit to the same block protects exactly 1 MB. A limit block numerically below the base block turns the window off without any further signalling. A capability input says whether the window exists at all. When it is low, base and limit are read-only, read back as zero and never produce a hit.

Register select encoding on `reg_sel`: 0 = base, 1 = limit, 2 = control (bit 0 enable, read/write; bit 1 protection-active status, read-only), 3 = unused (reads zero, writes have no effect).

Top module: `dprot_range_chk`

## Requirements
- R1: After reset the base, limit and control words read as 0x00000000, `prot_active` is 0 and `hit` is 0.
- R2: A write to base or limit stores only bits 31:20. Bits 19:0 always read as zero, so writing 0xFFFFFFFF reads back 0xFFF00000.
- R3: With protection active, the capability input high and limit block ≥ base block, an address A with bit 32 clear hits when {base,20'h00000} ≤ A ≤ {limit,20'hFFFFF}. The limit's last byte hits and the byte just above it does not.
- R4: When base and limit hold the same block B, exactly the addresses B·2^20 through B·2^20+0xFFFFF hit.
- R5: When the limit block is below the base block, no address hits.
- R6: While the capability input is low, base and limit read as zero, writes to them are dropped, and `hit` stays 0.
- R7: A write to base or limit in a cycle where `prot_active` is 1 is ignored and the old value is kept.
- R8: `prot_active` equals the control enable bit as it stood one clock earlier.
- R9: `hit` is registered: it is 1 only in the cycle after a cycle with `chk_valid` high and a matching address, and 0 otherwise.
- R10: An address with bit 32 set (at or above 4 GB) never hits.
- R11: An address below the base block's first byte never hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_region | input | 1 | High when the protected window is supported |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 base, 1 limit, 2 control) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| chk_valid | input | 1 | Address-check strobe |
| chk_addr | input | 33 | DMA request address; bit 32 marks 4 GB and above |
| hit | output | 1 | Request falls in the active window (one cycle after the strobe) |
| prot_active | output | 1 | Protection-active status |

## Verification
The checker watches, on every cycle, the parts of the block that hold in any state: status tracks the enable one clock late, the stored base and limit stay frozen while protection is active, and a hit needs a strobe one cycle earlier. It also checks that a high address, an inverted window or a low capability input never yields a hit, and that the reserved low bits and unsupported registers read as zero. The exact placement of the window edges cannot be seen from one cycle alone: the inclusive last byte of the limit block, the first byte of the base, the one-block window, and that a dropped write leaves the old value readable. These are shown by the bench's directed probes and by its random traffic compared against a model.

// File: rtl/dprot_pkg.sv
package dprot_pkg;

  typedef enum logic [1:0] {
    SEL_BASE  = 2'd0,
    SEL_LIMIT = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_NONE  = 2'd3
  } dprot_sel_e;

  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_STAT_BIT = 1;

endpackage

// File: rtl/dprot_regs.sv
module dprot_regs
  import dprot_pkg::*;
#(
  parameter int unsigned PA_W  = 32,
  parameter int unsigned GRAN  = 20,
  localparam int unsigned BLK_W = PA_W - GRAN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_region,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [PA_W-1:0]  reg_wdata,
  input  logic             prot_active,
  output logic [BLK_W-1:0] base_blk,
  output logic [BLK_W-1:0] lim_blk,
  output logic             ctl_en,
  output logic             wr_base_ok,
  output logic             wr_lim_ok,
  output logic [PA_W-1:0]  reg_rdata
);

  dprot_sel_e sel;
  logic       unlocked;
  logic       wr_ctl;

  assign sel        = dprot_sel_e'(reg_sel);
  // Base/limit are writable only when supported and not frozen by active protection
  assign unlocked   = cap_region && !prot_active;
  assign wr_base_ok = reg_wr && unlocked && (sel == SEL_BASE);
  assign wr_lim_ok  = reg_wr && unlocked && (sel == SEL_LIMIT);
  assign wr_ctl     = reg_wr && (sel == SEL_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_blk <= '0;
      lim_blk  <= '0;
      ctl_en   <= 1'b0;
    end else begin
      if (wr_base_ok) base_blk <= reg_wdata[PA_W-1:GRAN];
      if (wr_lim_ok)  lim_blk  <= reg_wdata[PA_W-1:GRAN];
      if (wr_ctl)     ctl_en   <= reg_wdata[CTRL_EN_BIT];
    end
  end

  function automatic logic [PA_W-1:0] blk_word(input logic [BLK_W-1:0] blk,
                                               input logic present);
    return present ? {blk, {GRAN{1'b0}}} : '0;
  endfunction

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_BASE:  reg_rdata = blk_word(base_blk, cap_region);
      SEL_LIMIT: reg_rdata = blk_word(lim_blk, cap_region);
      SEL_CTRL: begin
        reg_rdata[CTRL_EN_BIT]   = ctl_en;
        reg_rdata[CTRL_STAT_BIT] = prot_active;
      end
      SEL_NONE:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/dprot_status.sv
module dprot_status (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_en,
  output logic prot_active
);

  always_ff @(posedge clk) begin
    if (!rst_n) prot_active <= 1'b0;
    else        prot_active <= ctl_en;
  end

endmodule

// File: rtl/dprot_matcher.sv
module dprot_matcher #(
  parameter int unsigned PA_W  = 32,
  parameter int unsigned GRAN  = 20,
  localparam int unsigned BLK_W = PA_W - GRAN,
  localparam int unsigned CHK_W = PA_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chk_valid,
  input  logic [CHK_W-1:0] chk_addr,
  input  logic [BLK_W-1:0] base_blk,
  input  logic [BLK_W-1:0] lim_blk,
  input  logic             prot_active,
  input  logic             cap_region,
  output logic             region_ok,
  output logic             addr_in,
  output logic             hit
);

  // First protected byte: base block with low bits cleared
  function automatic logic [PA_W-1:0] lo_bound(input logic [BLK_W-1:0] blk);
    return {blk, {GRAN{1'b0}}};
  endfunction

  // Last protected byte: limit block with low bits forced to ones
  function automatic logic [PA_W-1:0] hi_bound(input logic [BLK_W-1:0] blk);
    return {blk, {GRAN{1'b1}}};
  endfunction

  logic below4g;

  assign region_ok = cap_region && (lim_blk >= base_blk);
  assign below4g   = !chk_addr[CHK_W-1];
  assign addr_in   = below4g
                  && (chk_addr[PA_W-1:0] >= lo_bound(base_blk))
                  && (chk_addr[PA_W-1:0] <= hi_bound(lim_blk));

  always_ff @(posedge clk) begin
    if (!rst_n) hit <= 1'b0;
    else        hit <= chk_valid && prot_active && region_ok && addr_in;
  end

endmodule

// File: rtl/dprot_range_chk.sv
module dprot_range_chk #(
  parameter int unsigned PA_W = 32,
  parameter int unsigned GRAN = 20,
  localparam int unsigned BLK_W = PA_W - GRAN,
  localparam int unsigned CHK_W = PA_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_region,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [PA_W-1:0]  reg_wdata,
  output logic [PA_W-1:0]  reg_rdata,
  input  logic             chk_valid,
  input  logic [CHK_W-1:0] chk_addr,
  output logic             hit,
  output logic             prot_active
);

  logic [BLK_W-1:0] base_blk;
  logic [BLK_W-1:0] lim_blk;
  logic             ctl_en;
  logic             wr_base_ok;
  logic             wr_lim_ok;
  logic             region_ok;
  logic             addr_in;

  dprot_regs #(.PA_W(PA_W), .GRAN(GRAN)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_region (cap_region),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .prot_active(prot_active),
    .base_blk   (base_blk),
    .lim_blk    (lim_blk),
    .ctl_en     (ctl_en),
    .wr_base_ok (wr_base_ok),
    .wr_lim_ok  (wr_lim_ok),
    .reg_rdata  (reg_rdata)
  );

  dprot_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_en     (ctl_en),
    .prot_active(prot_active)
  );

  dprot_matcher #(.PA_W(PA_W), .GRAN(GRAN)) u_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .chk_valid  (chk_valid),
    .chk_addr   (chk_addr),
    .base_blk   (base_blk),
    .lim_blk    (lim_blk),
    .prot_active(prot_active),
    .cap_region (cap_region),
    .region_ok  (region_ok),
    .addr_in    (addr_in),
    .hit        (hit)
  );

endmodule

// File: rtl/dprot_range_chk_sva.sv
module dprot_range_chk_sva #(
  parameter int unsigned PA_W = 32,
  parameter int unsigned GRAN = 20,
  localparam int unsigned BLK_W = PA_W - GRAN,
  localparam int unsigned CHK_W = PA_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cap_region,
  input logic [1:0]       reg_sel,
  input logic [PA_W-1:0]  reg_rdata,
  input logic             chk_valid,
  input logic [CHK_W-1:0] chk_addr,
  input logic             hit,
  input logic             prot_active,
  input logic             ctl_en,
  input logic [BLK_W-1:0] base_blk,
  input logic [BLK_W-1:0] lim_blk,
  input logic             wr_base_ok,
  input logic             wr_lim_ok
);

  a_r8_status_on: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_en |=> prot_active);

  a_r8_status_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> !prot_active);

  a_r7_frozen_regs: assert property (@(posedge clk) disable iff (!rst_n)
    prot_active |=> ($stable(base_blk) && $stable(lim_blk)));

  a_r7_no_write_grant: assert property (@(posedge clk) disable iff (!rst_n)
    prot_active |-> !(wr_base_ok || wr_lim_ok));

  a_r9_hit_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(chk_valid));

  a_r10_high_addr_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && chk_addr[CHK_W-1]) |=> !hit);

  a_r5_inverted_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_blk < base_blk) |=> !hit);

  a_r6_nocap_miss: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_region |=> !hit);

  a_r6_nocap_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_region && (reg_sel != 2'd2)) |-> (reg_rdata == '0));

  a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel != 2'd2) |-> (reg_rdata[GRAN-1:0] == '0));

  a_r9_hit_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(prot_active));

endmodule

bind dprot_range_chk dprot_range_chk_sva #(.PA_W(PA_W), .GRAN(GRAN)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .cap_region (cap_region),
  .reg_sel    (reg_sel),
  .reg_rdata  (reg_rdata),
  .chk_valid  (chk_valid),
  .chk_addr   (chk_addr),
  .hit        (hit),
  .prot_active(prot_active),
  .ctl_en     (ctl_en),
  .base_blk   (base_blk),
  .lim_blk    (lim_blk),
  .wr_base_ok (wr_base_ok),
  .wr_lim_ok  (wr_lim_ok)
);

// File: tb/dprot_range_chk_test.sv
module dprot_range_chk_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_region = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        chk_valid = 1'b0;
  logic [32:0] chk_addr = '0;
  logic        hit;
  logic        prot_active;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // Bench-side model
  logic [11:0] m_base = '0, m_lim = '0;
  logic        m_en = 1'b0, m_stat = 1'b0, m_hit = 1'b0;

  always #10 clk = ~clk;

  dprot_range_chk uut (
    .clk(clk), .rst_n(rst_n), .cap_region(cap_region), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .chk_valid(chk_valid), .chk_addr(chk_addr), .hit(hit),
    .prot_active(prot_active)
  );

  // Region membership stated as 64-bit arithmetic on byte addresses
  function automatic bit exp_hit(input logic [32:0] a, input logic [11:0] b,
                                 input logic [11:0] l, input bit act, input bit cap);
    longint unsigned lo, hi, av;
    lo = longint'(b) * 64'h100000;
    hi = longint'(l) * 64'h100000 + 64'hFFFFF;
    av = longint'(a);
    if (!act || !cap) return 1'b0;
    if (l < b) return 1'b0;
    if (av >= 64'h1_0000_0000) return 1'b0;
    return (av >= lo) && (av <= hi);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [1:0] s);
    case (s)
      2'd0: return cap_region ? {m_base, 20'h0} : 32'h0;
      2'd1: return cap_region ? {m_lim, 20'h0} : 32'h0;
      2'd2: return {30'h0, m_stat, m_en};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // One clock: update the model from the inputs seen at the edge, then
  // check hit at the following falling edge.
  task automatic cycle(input string req);
    bit old_stat;
    @(posedge clk);
    old_stat = m_stat;
    m_hit = chk_valid && exp_hit(chk_addr, m_base, m_lim, old_stat, cap_region);
    if (reg_wr && cap_region && !old_stat && reg_sel == 2'd0) m_base = reg_wdata[31:20];
    if (reg_wr && cap_region && !old_stat && reg_sel == 2'd1) m_lim = reg_wdata[31:20];
    m_stat = m_en;
    if (reg_wr && reg_sel == 2'd2) m_en = reg_wdata[0];
    @(negedge clk);
    check(req, {31'h0, hit}, {31'h0, m_hit});
    reg_wr = 1'b0;
    chk_valid = 1'b0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    cycle("R9");
  endtask

  task automatic rd_check(input string req, input logic [1:0] s);
    reg_sel = s;
    #1;
    check(req, reg_rdata, exp_rd(s));
  endtask

  task automatic probe(input string req, input logic [32:0] a, input bit want);
    chk_valid = 1'b1; chk_addr = a;
    cycle(req);
    check(req, {31'h0, hit}, {31'h0, want});
  endtask

  task automatic set_prot(input bit on);
    wr(2'd2, {31'h0, on});
    cycle("R8");
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    rd_check("R1", 2'd0);
    rd_check("R1", 2'd1);
    rd_check("R1", 2'd2);
    check("R1", {30'h0, prot_active, hit}, 32'h0);

    // R2: all-ones probe of alignment
    wr(2'd0, 32'hFFFF_FFFF);
    check("R2", reg_rdata, 32'hFFF0_0000);
    wr(2'd1, 32'hFFFF_FFFF);
    rd_check("R2", 2'd1);
    check("R2", reg_rdata, 32'hFFF0_0000);

    // R3/R11: window 0x100..0x1FF blocks
    wr(2'd0, 32'h1000_0ABC);
    wr(2'd1, 32'h1FF0_0000);
    // R8: status one cycle after enable
    wr(2'd2, 32'h1);
    check("R8", {31'h0, prot_active}, 32'h0);
    cycle("R8");
    check("R8", {31'h0, prot_active}, 32'h1);
    rd_check("R8", 2'd2);
    probe("R3", 33'h0_1FFF_FFFF, 1'b1);
    probe("R3", 33'h0_2000_0000, 1'b0);
    probe("R3", 33'h0_1000_0000, 1'b1);
    probe("R11", 33'h0_0FFF_FFFF, 1'b0);
    probe("R10", 33'h1_1000_0000, 1'b0);
    // R9: no strobe, no hit
    chk_addr = 33'h0_1500_0000;
    cycle("R9");
    check("R9", {31'h0, hit}, 32'h0);

    // R7: writes while active are dropped
    wr(2'd0, 32'h0500_0000);
    rd_check("R7", 2'd0);
    check("R7", reg_rdata, 32'h1000_0000);
    wr(2'd1, 32'h0600_0000);
    rd_check("R7", 2'd1);
    check("R7", reg_rdata, 32'h1FF0_0000);

    // R4: one-block window
    set_prot(1'b0);
    wr(2'd0, 32'h3000_0000);
    wr(2'd1, 32'h3000_0000);
    set_prot(1'b1);
    probe("R4", 33'h0_3000_0000, 1'b1);
    probe("R4", 33'h0_300F_FFFF, 1'b1);
    probe("R4", 33'h0_3010_0000, 1'b0);
    probe("R4", 33'h0_2FFF_FFFF, 1'b0);

    // R5: inverted window
    set_prot(1'b0);
    wr(2'd1, 32'h2FF0_0000);
    set_prot(1'b1);
    probe("R5", 33'h0_2FF0_0000, 1'b0);
    probe("R5", 33'h0_3000_0000, 1'b0);

    // R6: unsupported window
    set_prot(1'b0);
    wr(2'd1, 32'h4000_0000);
    cap_region = 1'b0;
    rd_check("R6", 2'd0);
    check("R6", reg_rdata, 32'h0);
    wr(2'd0, 32'h0100_0000);
    set_prot(1'b1);
    probe("R6", 33'h0_3800_0000, 1'b0);
    set_prot(1'b0);
    cap_region = 1'b1;
    rd_check("R6", 2'd0);
    check("R6", reg_rdata, 32'h3000_0000);

    // Random traffic against the model
    void'($urandom(32'd1357));
    for (int i = 0; i < 4000; i++) begin
      int op;
      op = $urandom_range(0, 99);
      cap_region = ($urandom_range(0, 19) != 0);
      if (op < 8) begin
        reg_wr = 1'b1; reg_sel = 2'($urandom_range(0, 1));
        reg_wdata = {4'h0, 8'($urandom), 20'($urandom)};
      end else if (op < 12) begin
        reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = {31'h0, 1'($urandom)};
      end else if (op < 14) begin
        reg_wr = 1'b1; reg_sel = 2'd3; reg_wdata = $urandom;
      end
      if ($urandom_range(0, 3) != 0) begin
        int k;
        chk_valid = 1'b1;
        k = $urandom_range(0, 5);
        case (k)
          0: chk_addr = {1'b0, m_base, 20'h0};
          1: chk_addr = {1'b0, m_lim, 20'hFFFFF};
          2: chk_addr = {1'b0, m_lim, 20'hFFFFF} + 33'd1;
          3: chk_addr = {1'b0, m_base, 20'h0} - 33'd1;
          4: chk_addr = {1'b1, 4'h0, 8'($urandom), 20'($urandom)};
          default: chk_addr = {5'h0, 8'($urandom), 20'($urandom)};
        endcase
      end
      cycle("R3");
      rd_check("R2", 2'($urandom_range(0, 3)));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule